// File: doc/BRIEF.md
# Four-Channel Shadowed PWM Generator

This block produces a number of independent pulse-width-modulated outputs, four by default. Each channel has its own small register window on a simple synchronous register bus. In that window software sets a clock divider (prescale), a step count per period (modulus), a high-time step count (duty) and a run flag. A channel's step counter advances once every prescale+1 clocks. Its output is high while the step count is below the duty value.

Software changes the waveform by writing the divider and modulus first and the duty value last. Those writes only stage new values. The duty write arms a commit, and the commit transfers all three staged values into the active set at the end of the period that is running. A period therefore never mixes old and new settings. Setting the run flag loads the staged values at once and starts a fresh period. Clearing the run flag drives the output low and clears the counters.

Top module: `pwm_multi_shadow`

## Requirements
- R1: A byte address is formed as channel index times 32 plus a register offset. Offset 0x00 holds the prescale in bits [7:0]. Offset 0x04 holds the modulus in bits [7:0]. Offset 0x08 holds the duty in bits [15:0]. Offset 0x18 holds the run flag in bit 0.
- R2: A read (rd_en high at a clock edge) returns the staged register value on rdata after that edge, with bits outside the field reading zero. rdata is zero after any edge with rd_en low.
- R3: Offsets other than the four listed read as zero, and writes to them change no register and no output.
- R4: A running channel has a period of (prescale+1)×modulus clocks. Its output is high for the first (prescale+1)×duty clocks of each period.
- R5: A duty of zero gives a constant low output. A duty equal to or above the modulus gives a constant high output.
- R6: Writes to prescale or modulus alone do not change the output waveform.
- R7: A duty write commits the staged prescale, modulus and duty. On a running channel they take effect at the next period boundary, and the period in progress completes with the old values.
- R8: Writing 0 to the run flag drives the output low from the next clock and resets the prescaler and step counter.
- R9: Writing 1 to the run flag of a stopped channel loads the staged values immediately and starts a new period with the output in its first step.
- R10: An active modulus of zero holds the output low. A pending commit is accepted on the next clock.
- R11: Writes and commits on one channel do not change the timing or output of any other channel.
- R12: After reset every register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registers and the counters |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register bus |
| rd_en | input | 1 | Read strobe for the register bus |
| addr | input | ADDR_W (7) | Byte address: channel index above bit 5, offset below |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| pwm_o | output | N_CH (4) | One waveform output per channel |

## Verification
The bench builds the block with its default values: four channels, 8-bit prescale and modulus, and 16-bit duty. Those small counters keep whole periods of a few clocks to a few dozen clocks within reach. This lets the bench cover commits that land mid-period, a duty equal to the modulus, a zero modulus and a restart after disable in a short run. A step-level model of every channel is compared with all outputs and the read data on each clock. Windowed high-time counts add an independent check of the period and duty arithmetic.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
   localparam int unsigned REG_SHIFT = 5;
   localparam int unsigned OFS_W     = REG_SHIFT;
   typedef logic [OFS_W-1:0] ofs_t;
   localparam ofs_t OFS_PRE  = 5'h00;
   localparam ofs_t OFS_MOD  = 5'h04;
   localparam ofs_t OFS_DUTY = 5'h08;
   localparam ofs_t OFS_RUN  = 5'h18;
endpackage

// File: rtl/pwm_stage_regs.sv
module pwm_stage_regs
   import pwm_shadow_pkg::*;
#(
   parameter int PRE_W  = 8,
   parameter int MOD_W  = 8,
   parameter int DUTY_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  ofs_t              ofs,
   input  logic [DATA_W-1:0] wdata,
   output logic [PRE_W-1:0]  stg_pre,
   output logic [MOD_W-1:0]  stg_mod,
   output logic [DUTY_W-1:0] stg_duty,
   output logic              run_q,
   output logic              commit_o,
   output logic              start_o,
   output logic [DATA_W-1:0] rd_word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_pre  <= '0;
         stg_mod  <= '0;
         stg_duty <= '0;
         run_q    <= 1'b0;
      end else if (wr_sel) begin
         case (ofs)
            OFS_PRE:  stg_pre  <= wdata[PRE_W-1:0];
            OFS_MOD:  stg_mod  <= wdata[MOD_W-1:0];
            OFS_DUTY: stg_duty <= wdata[DUTY_W-1:0];
            OFS_RUN:  run_q    <= wdata[0];
            default:  ;
         endcase
      end
   end

   assign commit_o = wr_sel && (ofs == OFS_DUTY);
   assign start_o  = wr_sel && (ofs == OFS_RUN) && wdata[0] && !run_q;

   always_comb begin
      rd_word = '0;
      case (ofs)
         OFS_PRE:  rd_word[PRE_W-1:0]  = stg_pre;
         OFS_MOD:  rd_word[MOD_W-1:0]  = stg_mod;
         OFS_DUTY: rd_word[DUTY_W-1:0] = stg_duty;
         OFS_RUN:  rd_word[0]          = run_q;
         default:  rd_word = '0;
      endcase
   end
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
   parameter int PRE_W  = 8,
   parameter int MOD_W  = 8,
   parameter int DUTY_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              start,
   input  logic              commit,
   input  logic [PRE_W-1:0]  stg_pre,
   input  logic [MOD_W-1:0]  stg_mod,
   input  logic [DUTY_W-1:0] stg_duty,
   output logic              pwm_o
);
   logic [PRE_W-1:0]  act_pre, pre_cnt;
   logic [MOD_W-1:0]  act_mod, step;
   logic [DUTY_W-1:0] act_duty;
   logic              pend;
   logic              stopped, at_end, boundary, load;

   assign stopped  = (act_mod == '0);
   assign at_end   = (pre_cnt == act_pre) && (step == act_mod - 1'b1);
   assign boundary = stopped || at_end;
   assign load     = run && pend && boundary;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_pre  <= '0;
         act_mod  <= '0;
         act_duty <= '0;
         pre_cnt  <= '0;
         step     <= '0;
         pend     <= 1'b0;
      end else begin
         if (start || load) begin
            act_pre  <= stg_pre;
            act_mod  <= stg_mod;
            act_duty <= stg_duty;
            pre_cnt  <= '0;
            step     <= '0;
         end else if (!run) begin
            pre_cnt <= '0;
            step    <= '0;
         end else if (!stopped) begin
            if (pre_cnt == act_pre) begin
               pre_cnt <= '0;
               step    <= (step == act_mod - 1'b1) ? '0 : step + 1'b1;
            end else begin
               pre_cnt <= pre_cnt + 1'b1;
            end
         end
         pend <= start ? 1'b0 : ((pend && !load) || commit);
      end
   end

   assign pwm_o = run && !stopped && (DUTY_W'(step) < act_duty);

   AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !stopped) |-> (step < act_mod)); // R4
   AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (pre_cnt <= act_pre)); // R4
   AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !load) |=> ($stable(act_mod) && $stable(act_duty) && $stable(act_pre))); // R7
   AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> (pre_cnt == '0 && step == '0 && !pwm_o)); // R8
   AST_START_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (step == '0 && pre_cnt == '0 && !pend)); // R9
endmodule

// File: rtl/pwm_multi_shadow.sv
module pwm_multi_shadow
   import pwm_shadow_pkg::*;
#(
   parameter int N_CH   = 4,
   parameter int PRE_W  = 8,
   parameter int MOD_W  = 8,
   parameter int DUTY_W = 16,
   parameter int DATA_W = 32,
   localparam int CH_W   = $clog2(N_CH),
   localparam int ADDR_W = CH_W + REG_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [N_CH-1:0]   pwm_o
);
   if (N_CH < 2 || (1 << CH_W) != N_CH) begin : g_bad_count
      $error("N_CH must be a power of two, at least 2");
   end
   if (PRE_W > DATA_W || MOD_W > DATA_W || DUTY_W > DATA_W) begin : g_bad_data
      $error("field widths must fit the data bus");
   end
   if (DUTY_W < MOD_W) begin : g_bad_duty
      $error("DUTY_W must cover MOD_W");
   end

   logic [CH_W-1:0]   ch_idx;
   ofs_t              ofs;
   logic [DATA_W-1:0] ch_rd [N_CH];

   assign ch_idx = addr[ADDR_W-1:REG_SHIFT];
   assign ofs    = addr[REG_SHIFT-1:0];

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      logic              sel, run, commit, start;
      logic [PRE_W-1:0]  stg_pre;
      logic [MOD_W-1:0]  stg_mod;
      logic [DUTY_W-1:0] stg_duty;
      logic [DATA_W-1:0] rd_word;

      assign sel = wr_en && (ch_idx == CH_W'(g));

      pwm_stage_regs #(.PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W), .DATA_W(DATA_W)) u_regs (
         .clk(clk), .rst_n(rst_n), .wr_sel(sel), .ofs(ofs), .wdata(wdata),
         .stg_pre(stg_pre), .stg_mod(stg_mod), .stg_duty(stg_duty),
         .run_q(run), .commit_o(commit), .start_o(start), .rd_word(rd_word));

      pwm_chan_core #(.PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)) u_core (
         .clk(clk), .rst_n(rst_n), .run(run), .start(start), .commit(commit),
         .stg_pre(stg_pre), .stg_mod(stg_mod), .stg_duty(stg_duty),
         .pwm_o(pwm_o[g]));

      assign ch_rd[g] = rd_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= ch_rd[ch_idx];
      else            rdata <= '0;
   end

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0)); // R2
endmodule

// File: tb/pwm_multi_shadow_tb_top.sv
module pwm_multi_shadow_tb_top;
   localparam int N = 4;
   localparam int AW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [N-1:0]  pwm_o;

   int    checks = 0, failures = 0, cyc = 0;
   bit    done = 1'b0;
   string cur_req = "R12";

   // behavioural reference state
   int s_pre[N], s_mod[N], s_duty[N], s_run[N];
   int a_pre[N], a_mod[N], a_duty[N], pend[N], pc[N], st[N];
   int exp_rdata = 0;

   always #4 clk = ~clk; // 125 MHz

   pwm_multi_shadow dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o));

   function automatic int reg_val(int c, int o);
      case (o)
         'h00: return s_pre[c];
         'h04: return s_mod[c];
         'h08: return s_duty[c];
         'h18: return s_run[c];
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      int wch, wofs;
      wch  = int'(addr) / 32;
      wofs = int'(addr) % 32;
      if (!rst_n) begin
         for (int c = 0; c < N; c++) begin
            s_pre[c] = 0; s_mod[c] = 0; s_duty[c] = 0; s_run[c] = 0;
            a_pre[c] = 0; a_mod[c] = 0; a_duty[c] = 0;
            pend[c] = 0; pc[c] = 0; st[c] = 0;
         end
         exp_rdata = 0;
      end else begin
         exp_rdata = rd_en ? reg_val(wch, wofs) : 0;
         for (int c = 0; c < N; c++) begin
            bit me, start, commit, bnd;
            me     = wr_en && (wch == c);
            start  = me && wofs == 'h18 && wdata[0] && s_run[c] == 0;
            commit = me && wofs == 'h08;
            if (start) begin
               a_pre[c] = s_pre[c]; a_mod[c] = s_mod[c]; a_duty[c] = s_duty[c];
               pc[c] = 0; st[c] = 0; pend[c] = 0;
            end else if (s_run[c] == 0) begin
               pc[c] = 0; st[c] = 0;
               if (commit) pend[c] = 1;
            end else begin
               bnd = (a_mod[c] == 0) || (pc[c] == a_pre[c] && st[c] == a_mod[c] - 1);
               if (bnd && pend[c] != 0) begin
                  a_pre[c] = s_pre[c]; a_mod[c] = s_mod[c]; a_duty[c] = s_duty[c];
                  pc[c] = 0; st[c] = 0; pend[c] = 0;
               end else if (a_mod[c] != 0) begin
                  if (pc[c] == a_pre[c]) begin
                     pc[c] = 0;
                     st[c] = (st[c] == a_mod[c] - 1) ? 0 : st[c] + 1;
                  end else pc[c]++;
               end
               if (commit) pend[c] = 1;
            end
            if (me) begin
               case (wofs)
                  'h00: s_pre[c]  = int'(wdata[7:0]);
                  'h04: s_mod[c]  = int'(wdata[7:0]);
                  'h08: s_duty[c] = int'(wdata[15:0]);
                  'h18: s_run[c]  = int'(wdata[0]);
                  default: ;
               endcase
            end
         end
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         for (int c = 0; c < N; c++) begin
            bit e;
            e = (s_run[c] != 0) && (a_mod[c] != 0) && (st[c] < a_duty[c]);
            checks++;
            if (pwm_o[c] !== e) begin
               failures++;
               $display("FAIL %s ch%0d pwm_o actual=%b expected=%b at cycle %0d",
                        cur_req, c, pwm_o[c], e, cyc);
            end
         end
         checks++;
         if (rdata !== 32'(exp_rdata)) begin
            failures++;
            $display("FAIL %s rdata actual=%h expected=%h at cycle %0d",
                     cur_req, rdata, exp_rdata, cyc);
         end
      end
   end

   task automatic check_eq(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(int ch, int ofs, int unsigned d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(ch * 32 + ofs); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(int ch, int ofs, output int v);
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(ch * 32 + ofs);
      @(negedge clk);
      v = int'(rdata);
      rd_en = 1'b0;
   endtask

   task automatic count_high(int ch, int n, output int cnt);
      cnt = 0;
      repeat (n) begin
         @(negedge clk);
         cnt += int'(pwm_o[ch]);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         failures++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         finish_run();
      end
   end

   initial begin
      int v, h;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12: reset state
      cur_req = "R12";
      for (int c = 0; c < N; c++) begin
         rd(c, 'h00, v); check_eq("R12 prescale", v, 0);
         rd(c, 'h08, v); check_eq("R12 duty", v, 0);
         rd(c, 'h18, v); check_eq("R12 run", v, 0);
      end
      check_eq("R12 outputs", int'(pwm_o), 0);

      // R1 / R2: address map and field widths
      cur_req = "R1";
      wr(2, 'h00, 32'h1AB);
      rd(2, 'h00, v); check_eq("R1 ch2 prescale", v, 'hAB);
      rd(1, 'h00, v); check_eq("R1 ch1 untouched", v, 0);
      cur_req = "R2";
      wr(2, 'h08, 32'hDEAD_BEEF);
      rd(2, 'h08, v); check_eq("R2 duty field only", v, 'hBEEF);
      wr(2, 'h04, 32'h0000_0312);
      rd(2, 'h04, v); check_eq("R2 modulus field only", v, 'h12);

      // R4: ch0 prescale 2, modulus 5, duty 2 -> period 15, high 6
      cur_req = "R4";
      wr(0, 'h00, 2); wr(0, 'h04, 5); wr(0, 'h08, 2);
      wr(0, 'h18, 1);
      count_high(0, 30, h); check_eq("R4 high over two periods", h, 12);

      // R6: staging without commit leaves waveform alone
      cur_req = "R6";
      wr(0, 'h04, 3); wr(0, 'h00, 0);
      count_high(0, 30, h); check_eq("R6 waveform unchanged", h, 12);
      rd(0, 'h04, v); check_eq("R6 staged modulus readable", v, 3);

      // R7: duty write commits at the boundary -> period 3, high 1
      cur_req = "R7";
      wr(0, 'h08, 1);
      repeat (20) @(negedge clk);
      count_high(0, 30, h); check_eq("R7 new settings after boundary", h, 10);

      // R5: duty 0 and duty equal to modulus
      cur_req = "R5";
      wr(0, 'h08, 0);
      repeat (10) @(negedge clk);
      count_high(0, 12, h); check_eq("R5 duty zero low", h, 0);
      wr(0, 'h08, 3);
      repeat (10) @(negedge clk);
      count_high(0, 12, h); check_eq("R5 duty equal modulus high", h, 12);

      // R10: zero modulus stops the channel
      cur_req = "R10";
      wr(0, 'h04, 0); wr(0, 'h08, 1);
      repeat (10) @(negedge clk);
      count_high(0, 10, h); check_eq("R10 zero modulus low", h, 0);
      wr(0, 'h04, 4); wr(0, 'h08, 2);
      repeat (4) @(negedge clk);
      count_high(0, 8, h); check_eq("R10 commit leaves stopped state", h, 4);

      // R8: disable
      cur_req = "R8";
      wr(0, 'h18, 0);
      check_eq("R8 low right after disable", int'(pwm_o[0]), 0);
      count_high(0, 10, h); check_eq("R8 stays low", h, 0);

      // R9: enable loads staged values at once
      cur_req = "R9";
      wr(0, 'h00, 1);
      wr(0, 'h18, 1);
      check_eq("R9 high in first step", int'(pwm_o[0]), 1);
      count_high(0, 16, h); check_eq("R9 new period 8 high 4", h, 8);

      // R11: channel independence
      cur_req = "R11";
      wr(3, 'h00, 1); wr(3, 'h04, 6); wr(3, 'h08, 2); wr(3, 'h18, 1);
      wr(1, 'h00, 0); wr(1, 'h04, 10); wr(1, 'h08, 3); wr(1, 'h18, 1);
      wr(1, 'h08, 7);
      count_high(3, 24, h); check_eq("R11 ch3 unaffected by ch1 commit", h, 8);
      count_high(1, 20, h); check_eq("R11 ch1 new duty", h, 14);
      count_high(0, 16, h); check_eq("R11 ch0 unaffected", h, 8);

      // R3: unassigned offsets
      cur_req = "R3";
      wr(3, 'h0C, 32'hFFFF);
      wr(3, 'h14, 32'hFFFF);
      rd(3, 'h0C, v); check_eq("R3 hole reads zero", v, 0);
      rd(3, 'h14, v); check_eq("R3 hole reads zero", v, 0);
      rd(3, 'h08, v); check_eq("R3 duty untouched", v, 2);
      count_high(3, 24, h); check_eq("R3 ch3 waveform unchanged", h, 8);

      finish_run();
   end
endmodule